// File: doc/BRIEF.md
# Single-Issue Core Memory Sequencer

This block is the control state machine for a core that runs one instruction at a time and has no pipeline. It starts each instruction fetch, waits for the fetch response, waits for address translation when the instruction touches memory, and then runs the data access. It talks to two request/response ports, one for instructions and one for data. Each port has a valid/accept handshake, a retry strobe, and a response that can carry a negative acknowledgement. Decode, execution, the caches and the translation unit sit outside the block. The translation unit shows up here only as a done strobe and a fault flag.

A refused request is held in a retry state and is sent again only when that port raises its retry strobe. A negatively acknowledged response makes the block reissue the request in the same cycle. A drain request completes at once when the core is quiescent. Otherwise drain completion waits until the outstanding fetch, translation or data access finishes, and fetching then stays stopped until a resume is given. Activate, suspend, switch-out and switch-in are the lifecycle controls. A free-running cycle counter pauses while the core is switched out.

Status encodings and their names: Idle 0, Running 1, FetchRetry 2, FetchWait 3, XlateWait 4, DataRetry 5, DataWait 6, SwitchedOut 7.

Transitions:
- Idle to Running on activate.
- Idle or Running to SwitchedOut on switch-out.
- SwitchedOut to Idle on switch-in.
- Running to Idle on suspend.
- Running to FetchWait or FetchRetry on fetch issue.
- FetchRetry to FetchWait on an accepted retry.
- FetchWait to FetchRetry on a refused reissue.
- FetchWait to Running or XlateWait on fetch landing.
- XlateWait to DataWait or DataRetry on translation done.
- XlateWait to Running on translation fault.
- DataRetry to DataWait on an accepted retry.
- DataWait to DataRetry on a refused reissue.
- DataWait to Running on data landing.

Top module: `core_mem_seq`

## Requirements
- R1: After reset `status_o` is 0 (Idle), `cycles_o` is 0, and no request, `inst_done_o`, `fault_o`, `drain_done_o` or `proto_err_o` is driven.
- R2: `activate_i` in Idle moves the status to Running (1). The first fetch request is driven exactly `act_delay_i` cycles after Running is entered. Activate is ignored in every other status and does not reload the delay.
- R3: A request refused (accept low) moves that port to its retry status (2 fetch, 5 data). No request is driven there until the port's retry strobe arrives. The strobe resends the request in its own cycle, and acceptance moves the port to its wait status (3 fetch, 6 data).
- R4: A response with the negative acknowledgement set drives the request again in the same cycle. If that reissue is accepted the port stays in its wait status. If it is refused the port goes to its retry status.
- R5: A retry strobe on either port while the status is not that port's retry status makes `proto_err_o` high for exactly one cycle, one cycle after the strobe.
- R6: A good fetch response stays one cycle in FetchWait before it takes effect. A non-memory instruction (`if_is_mem_i` low with the response) then gives Running with a one-cycle `inst_done_o`, and the next fetch request is driven in that same cycle. A memory instruction goes to XlateWait (4).
- R7: Translation done without a fault drives the data request in the same cycle. With a fault, no data request is driven and the next cycle is Running with a one-cycle `fault_o` and no `inst_done_o`.
- R8: A good data response stays one cycle in DataWait. The next cycle is Running with a one-cycle `inst_done_o`.
- R9: `drain_req_i` in Idle, Running or SwitchedOut gives `drain_done_o` for one cycle on the next cycle. No fetch is issued after a drain until `resume_i` has been given.
- R10: `drain_req_i` in any other status is deferred. `drain_done_o` comes together with the completion of the outstanding access. On fetch completion the fetched instruction is discarded (no `inst_done_o`). On data completion `inst_done_o` and `drain_done_o` pulse together.
- R11: `suspend_i` in Running suppresses the fetch of that cycle and moves the status to Idle.
- R12: `switch_out_i` in Idle or Running moves the status to SwitchedOut (7). `switch_in_i` there returns the status to Idle.
- R13: `cycles_o` increases by one on every clock edge at which the status is not SwitchedOut, and holds while the status is SwitchedOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate_i | input | 1 | Start the core from Idle |
| act_delay_i | input | DLY_W | Cycles from activation to the first fetch |
| suspend_i | input | 1 | Stop fetching and return to Idle |
| switch_out_i | input | 1 | Hand the core off (enter SwitchedOut) |
| switch_in_i | input | 1 | Take the core back (SwitchedOut to Idle) |
| drain_req_i | input | 1 | Request a clean stop between accesses |
| resume_i | input | 1 | Allow fetching again after a drain |
| drain_done_o | output | 1 | One-cycle drain completion pulse |
| if_req_o | output | 1 | Instruction port request valid |
| if_accept_i | input | 1 | Instruction port accepts the request |
| if_retry_i | input | 1 | Instruction port retry strobe |
| if_rsp_i | input | 1 | Instruction response valid |
| if_nack_i | input | 1 | Instruction response is a negative acknowledgement |
| if_is_mem_i | input | 1 | Fetched instruction accesses data memory |
| xlat_done_i | input | 1 | Data address translation finished |
| xlat_fault_i | input | 1 | Translation finished with a fault |
| dm_req_o | output | 1 | Data port request valid |
| dm_accept_i | input | 1 | Data port accepts the request |
| dm_retry_i | input | 1 | Data port retry strobe |
| dm_rsp_i | input | 1 | Data response valid |
| dm_nack_i | input | 1 | Data response is a negative acknowledgement |
| status_o | output | 3 | Current status encoding |
| inst_done_o | output | 1 | One-cycle instruction completion pulse |
| fault_o | output | 1 | One-cycle translation fault advance pulse |
| proto_err_o | output | 1 | One-cycle retry protocol error pulse |
| cycles_o | output | CYC_W | Free-running cycle count |

## Verification
The assertions assume the following about the inputs:
- A port raises a response only while the block is waiting on that port.
- A response lasts one cycle and never arrives in the cycle the previous one is landing.
- Translation done is raised only in XlateWait.

The stimulus keeps to these rules because one task plays each port cycle by cycle from the observed status. That task draws refusal counts, negative acknowledgements, translation delays, faults and drains from the random generator. Retry strobes outside a retry status are driven on purpose, only in directed cases, to trigger the protocol error.

// File: rtl/cms_pkg.sv
package cms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RUN      = 3'd1,
        ST_IF_RETRY = 3'd2,
        ST_IF_WAIT  = 3'd3,
        ST_XLAT     = 3'd4,
        ST_DM_RETRY = 3'd5,
        ST_DM_WAIT  = 3'd6,
        ST_OFF      = 3'd7
    } cms_state_e;
endpackage

// File: rtl/cms_start_tmr.sv
module cms_start_tmr #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] value_i,
    input  logic             count_i,
    output logic             expired_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= value_i;
        else if (count_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && count_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/cms_cycle_ctr.sv
module cms_cycle_ctr #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CYC_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= '0;
        else if (en_i)
            count_o <= count_o + 1'b1;
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (count_o == $past(count_o) + 1'b1)); // R13
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(count_o)); // R13
endmodule

// File: rtl/core_mem_seq.sv
module core_mem_seq
    import cms_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             activate_i,
    input  logic [DLY_W-1:0] act_delay_i,
    input  logic             suspend_i,
    input  logic             switch_out_i,
    input  logic             switch_in_i,
    input  logic             drain_req_i,
    input  logic             resume_i,
    output logic             drain_done_o,
    output logic             if_req_o,
    input  logic             if_accept_i,
    input  logic             if_retry_i,
    input  logic             if_rsp_i,
    input  logic             if_nack_i,
    input  logic             if_is_mem_i,
    input  logic             xlat_done_i,
    input  logic             xlat_fault_i,
    output logic             dm_req_o,
    input  logic             dm_accept_i,
    input  logic             dm_retry_i,
    input  logic             dm_rsp_i,
    input  logic             dm_nack_i,
    output logic [2:0]       status_o,
    output logic             inst_done_o,
    output logic             fault_o,
    output logic             proto_err_o,
    output logic [CYC_W-1:0] cycles_o
);
    localparam int ST_W = $bits(cms_state_e);

    cms_state_e st_q, st_d;
    logic drained_q, drained_d, draining_q, draining_d;
    logic if_rsp_q, ismem_q, dm_rsp_q;
    logic inst_d, flt_d, ddone_d, perr_d;
    logic tmr_expired, start_ok, go, quiet, drain_pend, fin;

    // Activation is honoured only from Idle, and loses to switch-out and suspend
    assign start_ok = (st_q == ST_IDLE) && activate_i && !switch_out_i && !suspend_i;

    cms_start_tmr #(.DLY_W(DLY_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_ok),
        .value_i   (act_delay_i),
        .count_i   (st_q == ST_RUN),
        .expired_o (tmr_expired)
    );

    cms_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (st_q != ST_OFF),
        .count_o (cycles_o)
    );

    // Output process: request strobes and status
    always_comb begin
        go       = tmr_expired && !drained_q && !drain_req_i && !suspend_i && !switch_out_i;
        if_req_o = ((st_q == ST_RUN) && go)
                 || ((st_q == ST_IF_RETRY) && if_retry_i)
                 || ((st_q == ST_IF_WAIT) && if_rsp_i && if_nack_i);
        dm_req_o = ((st_q == ST_XLAT) && xlat_done_i && !xlat_fault_i)
                 || ((st_q == ST_DM_RETRY) && dm_retry_i)
                 || ((st_q == ST_DM_WAIT) && dm_rsp_i && dm_nack_i);
        status_o = ST_W'(st_q);
    end

    // Next-state process
    always_comb begin
        st_d       = st_q;
        inst_d     = 1'b0;
        flt_d      = 1'b0;
        ddone_d    = 1'b0;
        fin        = 1'b0;
        drained_d  = resume_i ? 1'b0 : drained_q;
        draining_d = draining_q;
        perr_d     = (if_retry_i && st_q != ST_IF_RETRY) || (dm_retry_i && st_q != ST_DM_RETRY);
        quiet      = (st_q == ST_IDLE) || (st_q == ST_RUN) || (st_q == ST_OFF);
        drain_pend = draining_q || (drain_req_i && !quiet);

        if (drain_req_i) begin
            if (quiet) begin
                ddone_d   = 1'b1;
                drained_d = 1'b1;
            end else begin
                draining_d = 1'b1;
            end
        end

        unique case (st_q)
            ST_IDLE: begin
                if (switch_out_i)  st_d = ST_OFF;
                else if (start_ok) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (switch_out_i)   st_d = ST_OFF;
                else if (suspend_i) st_d = ST_IDLE;
                else if (if_req_o)  st_d = if_accept_i ? ST_IF_WAIT : ST_IF_RETRY;
            end
            ST_IF_RETRY: begin
                if (if_retry_i && if_accept_i) st_d = ST_IF_WAIT;
            end
            ST_IF_WAIT: begin
                if (if_rsp_q) begin
                    fin = 1'b1;
                    if (drain_pend)   st_d = ST_RUN;
                    else if (ismem_q) st_d = ST_XLAT;
                    else begin
                        st_d   = ST_RUN;
                        inst_d = 1'b1;
                    end
                end else if (if_req_o && !if_accept_i) begin
                    st_d = ST_IF_RETRY;
                end
            end
            ST_XLAT: begin
                if (xlat_done_i) begin
                    if (xlat_fault_i) begin
                        st_d  = ST_RUN;
                        flt_d = 1'b1;
                        fin   = 1'b1;
                    end else begin
                        st_d = dm_accept_i ? ST_DM_WAIT : ST_DM_RETRY;
                    end
                end
            end
            ST_DM_RETRY: begin
                if (dm_retry_i && dm_accept_i) st_d = ST_DM_WAIT;
            end
            ST_DM_WAIT: begin
                if (dm_rsp_q) begin
                    st_d   = ST_RUN;
                    inst_d = 1'b1;
                    fin    = 1'b1;
                end else if (dm_req_o && !dm_accept_i) begin
                    st_d = ST_DM_RETRY;
                end
            end
            ST_OFF: begin
                if (switch_in_i) st_d = ST_IDLE;
            end
        endcase

        if (fin && drain_pend) begin
            ddone_d    = 1'b1;
            drained_d  = 1'b1;
            draining_d = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            drained_q    <= 1'b0;
            draining_q   <= 1'b0;
            if_rsp_q     <= 1'b0;
            ismem_q      <= 1'b0;
            dm_rsp_q     <= 1'b0;
            inst_done_o  <= 1'b0;
            fault_o      <= 1'b0;
            drain_done_o <= 1'b0;
            proto_err_o  <= 1'b0;
        end else begin
            st_q         <= st_d;
            drained_q    <= drained_d;
            draining_q   <= draining_d;
            if_rsp_q     <= (st_q == ST_IF_WAIT) && if_rsp_i && !if_nack_i;
            ismem_q      <= if_is_mem_i;
            dm_rsp_q     <= (st_q == ST_DM_WAIT) && dm_rsp_i && !dm_nack_i;
            inst_done_o  <= inst_d;
            fault_o      <= flt_d;
            drain_done_o <= ddone_d;
            proto_err_o  <= perr_d;
        end
    end

    AST_IF_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req_o && !if_accept_i) |=> (st_q == ST_IF_RETRY)); // R3
    AST_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IF_RETRY && !if_retry_i) |=> (st_q == ST_IF_RETRY)); // R3
    AST_DM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req_o && !dm_accept_i) |=> (st_q == ST_DM_RETRY)); // R3
    AST_NACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DM_WAIT && dm_rsp_i && dm_nack_i && dm_accept_i) |=> (st_q == ST_DM_WAIT)); // R4
    AST_PROTO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (if_retry_i && st_q != ST_IF_RETRY) |=> proto_err_o); // R5
    AST_FAULT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XLAT && xlat_done_i && xlat_fault_i) |=> (fault_o && st_q == ST_RUN && !inst_done_o)); // R7
    AST_DM_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DM_WAIT && dm_rsp_i && !dm_nack_i) |=> (st_q == ST_DM_WAIT && !inst_done_o)); // R8
    AST_DRAIN_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_i && (st_q == ST_IDLE || st_q == ST_RUN || st_q == ST_OFF)) |=> drain_done_o); // R9
    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done_o |-> !if_req_o); // R9
    AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !switch_in_i) |=> (st_q == ST_OFF)); // R12
endmodule

// File: tb/tb_core_mem_seq.sv
`timescale 1ns/1ps
module tb_core_mem_seq;
    localparam int DLY_W = 8;
    localparam int CYC_W = 32;
    localparam int S_IDLE = 0, S_RUN = 1, S_IFR = 2, S_IFW = 3, S_XL = 4, S_DMR = 5, S_DMW = 6, S_OFF = 7;

    logic clk = 1'b0;
    logic rst_n;
    logic activate_i, suspend_i, switch_out_i, switch_in_i, drain_req_i, resume_i;
    logic [DLY_W-1:0] act_delay_i;
    logic if_accept_i, if_retry_i, if_rsp_i, if_nack_i, if_is_mem_i;
    logic xlat_done_i, xlat_fault_i;
    logic dm_accept_i, dm_retry_i, dm_rsp_i, dm_nack_i;
    logic drain_done_o, if_req_o, dm_req_o, inst_done_o, fault_o, proto_err_o;
    logic [2:0] status_o;
    logic [CYC_W-1:0] cycles_o;

    int checks = 0;
    int errors = 0;
    logic [CYC_W-1:0] c0;

    core_mem_seq #(.DLY_W(DLY_W), .CYC_W(CYC_W)) dut (
        .clk(clk), .rst_n(rst_n), .activate_i(activate_i), .act_delay_i(act_delay_i),
        .suspend_i(suspend_i), .switch_out_i(switch_out_i), .switch_in_i(switch_in_i),
        .drain_req_i(drain_req_i), .resume_i(resume_i), .drain_done_o(drain_done_o),
        .if_req_o(if_req_o), .if_accept_i(if_accept_i), .if_retry_i(if_retry_i),
        .if_rsp_i(if_rsp_i), .if_nack_i(if_nack_i), .if_is_mem_i(if_is_mem_i),
        .xlat_done_i(xlat_done_i), .xlat_fault_i(xlat_fault_i),
        .dm_req_o(dm_req_o), .dm_accept_i(dm_accept_i), .dm_retry_i(dm_retry_i),
        .dm_rsp_i(dm_rsp_i), .dm_nack_i(dm_nack_i), .status_o(status_o),
        .inst_done_o(inst_done_o), .fault_o(fault_o), .proto_err_o(proto_err_o),
        .cycles_o(cycles_o)
    );

    always #2 clk = ~clk;

    function automatic int exp_issue(input bit accepted, input bit data_port);
        if (data_port) return accepted ? S_DMW : S_DMR;
        return accepted ? S_IFW : S_IFR;
    endfunction

    function automatic int exp_landing(input bit is_mem, input bit draining);
        if (draining) return S_RUN;
        return is_mem ? S_XL : S_RUN;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        activate_i = 0; suspend_i = 0; switch_out_i = 0; switch_in_i = 0;
        drain_req_i = 0; resume_i = 0; act_delay_i = '0;
        if_accept_i = 0; if_retry_i = 0; if_rsp_i = 0; if_nack_i = 0; if_is_mem_i = 0;
        xlat_done_i = 0; xlat_fault_i = 0;
        dm_accept_i = 0; dm_retry_i = 0; dm_rsp_i = 0; dm_nack_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clr();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One instruction; entered at a drive point in Running with the fetch due
    task automatic run_inst(input bit is_mem, input int if_ref, input bit if_nk, input bit flt,
                            input int dm_ref, input bit dm_nk, input int xw, input bit drn);
        if_accept_i = (if_ref == 0);
        #1;
        chk("R6 fetch issued in Running", if_req_o, 1);
        chk("R6 status Running at issue", status_o, S_RUN);
        for (int k = 0; k < if_ref; k++) begin
            tick(); #1;
            chk("R3 fetch held in retry", status_o, exp_issue(0, 0));
            chk("R3 no fetch resend without strobe", if_req_o, 0);
            tick();
            if_retry_i = 1; if_accept_i = (k == if_ref - 1); #1;
            chk("R3 fetch resend on strobe", if_req_o, 1);
        end
        tick(); #1;
        chk("R3 fetch accepted", status_o, exp_issue(1, 0));
        if (if_nk) begin
            if_rsp_i = 1; if_nack_i = 1; #1;
            chk("R4 fetch reissue on nack", if_req_o, 1);
            tick(); #1;
            chk("R4 refused reissue to retry", status_o, exp_issue(0, 0));
            if_retry_i = 1; if_accept_i = 1;
            tick(); #1;
            chk("R4 fetch wait after retry", status_o, exp_issue(1, 0));
        end
        if_rsp_i = 1; if_is_mem_i = is_mem;
        tick(); #1;
        chk("R6 fetch landing cycle", status_o, S_IFW);
        tick(); #1;
        chk("R6 fetch result", status_o, exp_landing(is_mem, 0));
        if (!is_mem) begin
            chk("R6 non-memory completes", inst_done_o, 1);
            return;
        end
        chk("R6 no completion for memory op", inst_done_o, 0);
        for (int w = 0; w < xw; w++) begin
            tick(); #1;
            chk("R7 waiting translation", status_o, S_XL);
            chk("R7 no data req before translation", dm_req_o, 0);
        end
        xlat_done_i = 1; xlat_fault_i = flt; dm_accept_i = (dm_ref == 0); #1;
        chk("R7 data req follows translation", dm_req_o, !flt);
        if (flt) begin
            tick(); #1;
            chk("R7 fault returns to Running", status_o, S_RUN);
            chk("R7 fault pulse", fault_o, 1);
            chk("R7 no completion on fault", inst_done_o, 0);
            return;
        end
        for (int k = 0; k < dm_ref; k++) begin
            tick(); #1;
            chk("R3 data held in retry", status_o, exp_issue(0, 1));
            chk("R3 no data resend without strobe", dm_req_o, 0);
            tick();
            dm_retry_i = 1; dm_accept_i = (k == dm_ref - 1); #1;
            chk("R3 data resend on strobe", dm_req_o, 1);
        end
        tick(); #1;
        chk("R3 data accepted", status_o, exp_issue(1, 1));
        if (dm_nk) begin
            dm_rsp_i = 1; dm_nack_i = 1; #1;
            chk("R4 data reissue on nack", dm_req_o, 1);
            tick(); #1;
            chk("R4 refused data reissue to retry", status_o, exp_issue(0, 1));
            dm_retry_i = 1; dm_accept_i = 1;
            tick(); #1;
            chk("R4 data wait after retry", status_o, exp_issue(1, 1));
        end
        if (drn) begin
            drain_req_i = 1;
            tick(); #1;
            chk("R10 drain deferred in data wait", drain_done_o, 0);
        end
        dm_rsp_i = 1;
        tick(); #1;
        chk("R8 data landing cycle", status_o, S_DMW);
        chk("R8 no completion while landing", inst_done_o, 0);
        tick(); #1;
        chk("R8 data completes to Running", status_o, S_RUN);
        chk("R8 completion pulse", inst_done_o, 1);
        if (drn) begin
            chk("R10 drain done with data completion", drain_done_o, 1);
            chk("R9 no fetch while drained", if_req_o, 0);
            resume_i = 1;
            tick();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20417));
        clr();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status_o, S_IDLE);
        chk("R1 reset cycles", cycles_o, 0);
        chk("R1 reset if_req", if_req_o, 0);
        chk("R1 reset dm_req", dm_req_o, 0);
        chk("R1 reset pulses", {inst_done_o, fault_o, drain_done_o, proto_err_o}, 0);
        rst_n = 1;
        tick(); #1;
        c0 = cycles_o;
        repeat (5) tick();
        #1;
        chk("R13 counter runs in Idle", cycles_o, c0 + 5);

        dm_retry_i = 1;
        tick(); #1;
        chk("R5 stray data retry flagged", proto_err_o, 1);
        tick(); #1;
        chk("R5 error is one cycle", proto_err_o, 0);

        drain_req_i = 1;
        tick(); #1;
        chk("R9 drain in Idle immediate", drain_done_o, 1);
        chk("R9 Idle kept", status_o, S_IDLE);
        resume_i = 1;
        tick();

        activate_i = 1; act_delay_i = 3;
        tick();
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R2 fetch waits for delay", if_req_o, 0);
            chk("R2 Running during delay", status_o, S_RUN);
            tick();
        end
        run_inst(0, 0, 0, 0, 0, 0, 0, 0);
        run_inst(1, 2, 1, 0, 1, 1, 2, 0);
        run_inst(1, 0, 0, 1, 0, 0, 1, 0);
        run_inst(1, 1, 0, 0, 0, 0, 0, 1);

        // Deferred drain during fetch wait, with ignored activate and stray retry
        if_accept_i = 1; #1;
        tick();
        activate_i = 1; act_delay_i = 9; if_retry_i = 1;
        tick(); #1;
        chk("R2 activate ignored outside Idle", status_o, S_IFW);
        chk("R5 stray fetch retry flagged", proto_err_o, 1);
        drain_req_i = 1;
        tick(); #1;
        chk("R10 drain deferred in fetch wait", drain_done_o, 0);
        if_rsp_i = 1;
        tick(); #1;
        chk("R6 landing while draining", status_o, S_IFW);
        tick(); #1;
        chk("R10 drain ends at fetch completion", drain_done_o, 1);
        chk("R10 fetched instruction discarded", inst_done_o, 0);
        chk("R10 status Running after drain", status_o, exp_landing(0, 1));
        chk("R9 no fetch while drained", if_req_o, 0);
        tick(); #1;
        chk("R9 still no fetch while drained", if_req_o, 0);
        resume_i = 1;
        tick(); #1;
        chk("R2 delay not reloaded by ignored activate", if_req_o, 1);

        drain_req_i = 1; #1;
        chk("R9 drain blocks fetch in Running", if_req_o, 0);
        tick(); #1;
        chk("R9 drain in Running immediate", drain_done_o, 1);
        resume_i = 1;
        tick();

        suspend_i = 1; #1;
        chk("R11 suspend suppresses fetch", if_req_o, 0);
        tick(); #1;
        chk("R11 suspend to Idle", status_o, S_IDLE);
        tick(); #1;
        chk("R11 no fetch in Idle", if_req_o, 0);

        switch_out_i = 1;
        tick(); #1;
        chk("R12 switched out", status_o, S_OFF);
        c0 = cycles_o;
        activate_i = 1;
        repeat (4) tick();
        #1;
        chk("R13 counter frozen when switched out", cycles_o, c0);
        chk("R2 activate ignored when switched out", status_o, S_OFF);
        drain_req_i = 1;
        tick(); #1;
        chk("R9 drain when switched out immediate", drain_done_o, 1);
        switch_in_i = 1; resume_i = 1;
        tick(); #1;
        chk("R12 switch in to Idle", status_o, S_IDLE);
        c0 = cycles_o;
        tick(); #1;
        chk("R13 counter resumes", cycles_o, c0 + 1);

        activate_i = 1; act_delay_i = 0;
        tick(); #1;
        chk("R2 zero delay fetches at once", if_req_o, 1);

        for (int n = 0; n < 40; n++) begin
            bit m, f;
            m = 1'($urandom % 2);
            f = ($urandom % 4) == 0;
            run_inst(m, int'($urandom % 3), 1'($urandom % 2), f, int'($urandom % 3),
                     1'($urandom % 2), int'($urandom % 4), m && !f && (($urandom % 6) == 0));
        end
        #1;
        chk("R6 Running after random run", status_o, S_RUN);
        finish_run();
    end
endmodule